// File: doc/BRIEF.md
# Infrared SIR Receive Pulse Decoder

This block sits between an infrared photodetector and a UART receiver. The detector line idles high when no light arrives, and each optical pulse shows up as a short low level. The decoder turns that return-to-zero pulse train into the level-coded (NRZ) stream that a UART deserialiser expects. A bit cell that holds a pulse becomes a full-width low bit. A cell without a pulse becomes a high bit.

Two enables pace the block. The first is a 16x baud tick, and sixteen of these make one bit cell. The second is a low-power reference tick. It is used only to qualify a start. After a synchronised falling edge, the line is looked at again on the first reference tick. A start is taken only if the line is still low on that tick. A single-clock spike is rejected. A pulse much narrower than 3/16 of a bit, as a low-power transmitter sends, is still accepted. This qualification does not depend on whether the link runs in normal or low-power mode. The output lags the optical stream by exactly one bit cell, so each cell can be judged as a whole before it is shown.

Top module: `sir_rx_decoder`

## Requirements
- R1: While reset is active, `nrz_o` is high. Reset also sets the input synchroniser to the idle (high) level.
- R2: While `ir_rx_i` stays high and no frame is in progress, `nrz_o` stays high.
- R3: A low level on `ir_rx_i` marks a light pulse. A falling edge, seen after a two-flop synchroniser, arms a start check. The start is accepted if the synchronised line is still low on the first `lp_tick_i` after arming. A pulse 10 clocks wide is accepted when `lp_tick_i` comes every 6 clocks.
- R4: If the synchronised line is back high on the first `lp_tick_i` after arming, the low is discarded. `nrz_o` stays high and no frame starts.
- R5: If no `lp_tick_i` arrives before the first bit cell ends (16 `tick16_i` pulses after arming), the low is discarded and `nrz_o` stays high.
- R6: Bit cells are 16 `tick16_i` pulses long. Cell 0 starts when the check is armed. Each cell ends on a `tick16_i`, and `nrz_o` changes only at a cell end. At that point `nrz_o` becomes low if a falling edge was seen in the cell just ended (the start counts for cell 0), and high otherwise. A falling edge that lands in the same cycle as a cell end belongs to the next cell.
- R7: A frame is FRAME_BITS cells long (10 by default). If the last cell holds no pulse, the block goes back to idle with `nrz_o` high and accepts the next start. A falling edge that lands on the last cell end arms a new start.
- R8: If the last cell of a frame holds a pulse, `nrz_o` is low for that bit. It returns high one cell later. Pulses during that extra cell are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_i | input | 1 | Raw detector line, idles high, low during a light pulse |
| tick16_i | input | 1 | One-cycle enable at 16 times the baud rate |
| lp_tick_i | input | 1 | One-cycle low-power reference enable used for start checks |
| nrz_o | output | 1 | NRZ receive line for the UART, idles high |

## Verification
A pulse edge takes three clock edges to become an armed check: two synchroniser flops and the state register. The output for cell k then appears at the (16(k+1))th `tick16_i` after arming. With a 4-clock tick, that edge falls up to three clocks before the nominal 64(k+1). The bench therefore samples bit k 35 clocks after that nominal point, which is mid-cell, so the tick phase and the synchroniser delay cannot move the result across a sample. Rejection cases (R4, R5, R8) are checked the same way at every cell position, so a wrongly started frame would show up as a low sample.

// File: rtl/sir_rx_pkg.sv
`timescale 1ns/1ps
package sir_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } sir_state_e;

  // true when a counter value is the final tick of a bit cell
  function automatic logic cell_last_tick(input int unsigned cnt,
                                          input int unsigned ticks_per_bit);
    return cnt == ticks_per_bit - 1;
  endfunction

  // true when a bit index is the final cell of a frame
  function automatic logic frame_last_bit(input int unsigned idx,
                                          input int unsigned frame_bits);
    return idx == frame_bits - 1;
  endfunction

endpackage

// File: rtl/sir_rx_sync.sv
`timescale 1ns/1ps
module sir_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign line_s_o = chain[STAGES-1];
  assign fall_o   = prev & ~chain[STAGES-1];

endmodule

// File: rtl/sir_rx_cellclk.sv
`timescale 1ns/1ps
module sir_rx_cellclk
  import sir_rx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic active_i,
  input  logic tick_i,
  output logic cell_end_o
);

  localparam int unsigned CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last    = cell_last_tick(int'(cnt), TICKS_PER_BIT);
  assign cell_end_o = active_i & tick_i & at_last & ~restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart_i) begin
      cnt <= '0;
    end else if (active_i && tick_i) begin
      if (at_last) cnt <= '0;
      else         cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sir_rx_ctrl.sv
`timescale 1ns/1ps
module sir_rx_ctrl
  import sir_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       line_s_i,
  input  logic       lp_tick_i,
  input  logic       cell_end_i,
  output sir_state_e state_o,
  output logic       restart_o,
  output logic       active_o,
  output logic       start_ok_o,
  output logic       glitch_drop_o,
  output logic       timeout_drop_o,
  output logic       nrz_o
);

  localparam int unsigned IW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  sir_state_e    state;
  logic [IW-1:0] bit_idx;
  logic          seen;
  logic          nrz;
  logic          last_bit;

  assign last_bit       = frame_last_bit(int'(bit_idx), FRAME_BITS);
  assign restart_o      = (state == ST_IDLE) & fall_i;
  assign active_o       = (state != ST_IDLE);
  assign start_ok_o     = (state == ST_ARM) & lp_tick_i & ~line_s_i;
  assign glitch_drop_o  = (state == ST_ARM) & lp_tick_i & line_s_i;
  assign timeout_drop_o = (state == ST_ARM) & cell_end_i & ~lp_tick_i;
  assign state_o        = state;
  assign nrz_o          = nrz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      seen    <= 1'b0;
      nrz     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fall_i) begin
            state   <= ST_ARM;
            bit_idx <= '0;
            seen    <= 1'b0;
          end
        end
        ST_ARM: begin
          if (glitch_drop_o || timeout_drop_o) begin
            state <= ST_IDLE;
          end else if (start_ok_o) begin
            state <= ST_RUN;
            if (cell_end_i) begin
              nrz     <= 1'b0;
              bit_idx <= IW'(1);
              seen    <= 1'b0;
            end else begin
              seen <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (cell_end_i) begin
            nrz <= ~seen;
            if (last_bit) begin
              bit_idx <= '0;
              if (seen) begin
                state <= ST_TAIL;
                seen  <= 1'b0;
              end else if (fall_i) begin
                state <= ST_ARM;
                seen  <= 1'b0;
              end else begin
                state <= ST_IDLE;
                seen  <= 1'b0;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              seen    <= fall_i;
            end
          end else begin
            seen <= seen | fall_i;
          end
        end
        ST_TAIL: begin
          if (cell_end_i) begin
            nrz   <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sir_rx_decoder.sv
`timescale 1ns/1ps
module sir_rx_decoder
  import sir_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS    = 10,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_rx_i,
  input  logic tick16_i,
  input  logic lp_tick_i,
  output logic nrz_o
);

  // named internal events, brought out for the bound checker
  logic       line_s;
  logic       fall;
  logic       restart;
  logic       active;
  logic       cell_end;
  logic       start_ok;
  logic       glitch_drop;
  logic       timeout_drop;
  sir_state_e state;

  sir_rx_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (ir_rx_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  sir_rx_cellclk #(
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) i_cellclk (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .active_i   (active),
    .tick_i     (tick16_i),
    .cell_end_o (cell_end)
  );

  sir_rx_ctrl #(
    .FRAME_BITS (FRAME_BITS)
  ) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .fall_i         (fall),
    .line_s_i       (line_s),
    .lp_tick_i      (lp_tick_i),
    .cell_end_i     (cell_end),
    .state_o        (state),
    .restart_o      (restart),
    .active_o       (active),
    .start_ok_o     (start_ok),
    .glitch_drop_o  (glitch_drop),
    .timeout_drop_o (timeout_drop),
    .nrz_o          (nrz_o)
  );

endmodule

// File: rtl/sir_rx_decoder_chk.sv
`timescale 1ns/1ps
module sir_rx_decoder_chk
  import sir_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick16_i,
  input logic       nrz_o,
  input sir_state_e state,
  input logic       fall,
  input logic       start_ok,
  input logic       glitch_drop,
  input logic       timeout_drop,
  input logic       cell_end
);

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_ARM) |-> nrz_o);

  // R3
  start_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (state == ST_RUN));

  // R4
  glitch_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_drop |=> (state == ST_IDLE && nrz_o));

  // R5
  timeout_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_drop |=> (state == ST_IDLE && nrz_o));

  // R6
  change_at_cell_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nrz_o) |-> $past(cell_end));

  // R6
  cell_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |-> tick16_i);

  // R7
  arm_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_ARM) |-> $past(fall));

  // R8
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> !nrz_o);

endmodule

bind sir_rx_decoder sir_rx_decoder_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick16_i     (tick16_i),
  .nrz_o        (nrz_o),
  .state        (state),
  .fall         (fall),
  .start_ok     (start_ok),
  .glitch_drop  (glitch_drop),
  .timeout_drop (timeout_drop),
  .cell_end     (cell_end)
);

// File: tb/test_sir_rx_decoder.sv
`timescale 1ns/1ps
module test_sir_rx_decoder;

  localparam int CELL   = 64;   // 16 ticks of 4 clocks
  localparam int NCELLS = 12;   // cells observed per frame run
  localparam int NVEC   = 6;

  // vector = {pulses per cell [11:0], pulse width [7:0], expected nrz per cell [11:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {12'h001, 8'd12, 12'hFFE},  // R6 start only
    {12'h1FF, 8'd12, 12'hE00},  // R6 all data pulses
    {12'h155, 8'd12, 12'hEAA},  // R6 alternating
    {12'h0CB, 8'd10, 12'hF34},  // R3 narrow pulses
    {12'h133, 8'd10, 12'hECC},  // R3 narrow pulses
    {12'h001, 8'd1,  12'hFFF}   // R4 one-clock spike
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_rx_i = 1'b1;
  logic tick16_i = 1'b0;
  logic lp_tick_i = 1'b0;
  logic lp_en = 1'b1;
  logic nrz_o;

  int total = 0;
  int bad = 0;
  int div16 = 0;
  int divlp = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    div16 = (div16 + 1) % 4;
    divlp = (divlp + 1) % 6;
    tick16_i <= (div16 == 0);
    lp_tick_i <= lp_en && (divlp == 0);
  end

  sir_rx_decoder i_sir_rx_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_rx_i   (ir_rx_i),
    .tick16_i  (tick16_i),
    .lp_tick_i (lp_tick_i),
    .nrz_o     (nrz_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: nrz actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one frame of pulses and sample each output cell mid-way
  task automatic run_frame(input string req, input logic [11:0] pulses,
                           input int width, input logic [11:0] exp);
    for (int c = 0; c < (NCELLS + 1) * CELL; c++) begin
      logic lo;
      @(negedge clk);
      lo = 1'b0;
      for (int k = 0; k < NCELLS; k++) begin
        int s;
        s = (k == 0) ? 0 : k * CELL + 16;
        if (pulses[k] && c >= s && c < s + width) lo = 1'b1;
      end
      ir_rx_i = ~lo;
      for (int k = 0; k < NCELLS; k++)
        if (c == CELL * (k + 1) + 35) chk(req, nrz_o, exp[k]);
    end
    ir_rx_i = 1'b1;
  endtask

  initial begin
    #3_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: output high in reset
    repeat (5) @(negedge clk);
    chk("R1", nrz_o, 1'b1);
    rst_n = 1'b1;
    // R2: long idle keeps the line high
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i % 50 == 49) chk("R2", nrz_o, 1'b1);
    end

    // table of frames, back to back (R7 re-arming)
    for (int v = 0; v < NVEC; v++) begin
      run_frame("R6/R7 vector", VEC[v][31:20], int'(VEC[v][19:12]), VEC[v][11:0]);
    end

    // R5: no reference tick during cell 0 -> discarded
    lp_en = 1'b0;
    run_frame("R5", 12'h001, 12, 12'hFFF);
    lp_en = 1'b1;

    // R8: pulse in last cell, then an ignored pulse in the extra cell
    run_frame("R8", 12'h601, 12, 12'hDFE);

    // R7: decoder still accepts a frame afterwards
    run_frame("R7", 12'h0CB, 12, 12'hF34);

    // R1: reset in the middle of a low output bit
    for (int c = 0; c < CELL + 40; c++) begin
      @(negedge clk);
      ir_rx_i = !(c < 12);
    end
    chk("R6 pre-reset low", nrz_o, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-frame", nrz_o, 1'b1);
    rst_n = 1'b1;
    repeat (3 * CELL) @(negedge clk);
    chk("R2 after reset", nrz_o, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule